// File: doc/BRIEF.md
# Prefixed Opcode Fetch and Decode Sequencer

This block is the front end of a small 8-bit accumulator processor with a 16-bit address space. It holds the program counter. It reads instruction bytes one at a time over a synchronous byte-read port and turns each instruction into a decoded record for the execute stage. The record holds the operation class, register and pair selectors, a condition code, an assembled immediate value and a base cycle cost.

Decoding splits the opcode into fields: x is bits 7:6, y is bits 5:3 and z is bits 2:0. Two more fields come from y: p is y shifted right by one, and q is the low bit of y. The byte 0xCB is a prefix. When the sequencer sees it, it fetches a second byte and decodes that byte from a separate table. Operand bytes are fetched after the opcode. A 16-bit operand arrives low byte first.

The finished record is presented with a valid signal and is held until the execute stage accepts it. An opcode that falls in an unused slot produces a one-cycle illegal pulse and no record.

Top module: `byte_op_fetch_decode`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the block requests address 0x0000 with `mem_rd` high. In those cycles `dec_valid` and `illegal_op` are low.
- R2: Each byte is fetched with `mem_rd` high and `mem_addr` equal to the program counter. The program counter then advances by one. The byte arrives on `mem_rdata` in the next cycle. Consecutive instructions occupy consecutive addresses.
- R3: For an unprefixed record, `dec_ysel` equals opcode bits 5:3, `dec_zsel` equals bits 2:0, `dec_pair` equals bits 5:4, and `dec_prefixed` is 0.
- R4: After 0xCB, exactly one more byte is fetched. The record has `dec_prefixed`=1, with `dec_ysel` and `dec_zsel` taken from bits 5:3 and 2:0 of that second byte. `dec_imm` is 0.
- R5: Opcodes 0x01/11/21/31/08, conditional and unconditional absolute jumps and calls (C2,CA,D2,DA,C3,C4,CC,D4,DC,CD) and 0xEA/0xFA take two operand bytes. `dec_imm` = {second, first}.
- R6: One operand byte is taken by (op&0xC7)==0x06, (op&0xC7)==0xC6, 0x18–0x38 step 8, 0xE0, 0xE8, 0xF0 and 0xF8. It is sign-extended for 0x18–0x38 step 8, 0xE8 and 0xF8, and zero-extended otherwise, except as given in R7. All other opcodes take no operand bytes.
- R7: For 0xE0/0xF0, `dec_imm` = 0xFF00 + n. For 0xE2/0xF2, `dec_imm` = 0xFF00 and no operand is fetched.
- R8: A restart opcode ((op&0xC7)==0xC7) gives `dec_imm` = y*8. Any other opcode without an operand gives `dec_imm` = 0.
- R9: For relative jumps, `dec_cond` is 4 ("always") for 0x18. For 0x20/28/30/38 it is y-4, where 0=NZ, 1=Z, 2=NC and 3=C.
- R10: `dec_cycles` has these values: 12 for 0x01/11/21/31, 8 for 0xF2, 12 for 0xE0/0xF0, 16 for 0xFA, 16 for every restart, and 12 for 0x34.
- R11: Opcodes D3, DB, DD, E3, E4, EB, EC, ED, F4, FC and FD raise `illegal_op` for exactly one cycle and produce no record. The next fetch is at the illegal opcode's address plus one.
- R12: Once `dec_valid` rises, the record stays stable and no fetch is made until `dec_accept` is sampled high. In the following cycle the next opcode fetch is issued.
- R13: Prefixed costs are 8 when the register selector is not 6. When it is 6, the cost is 12 for the bit-test group (x=1) and 16 for all other groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Read address (program counter) |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| dec_valid | output | 1 | Decoded record available |
| dec_accept | input | 1 | Execute stage takes the record |
| dec_class | output | 5 | Operation class code |
| dec_prefixed | output | 1 | Record came from the prefixed table |
| dec_ysel | output | 3 | y field (destination register or operation) |
| dec_zsel | output | 3 | z field (source register) |
| dec_pair | output | 2 | p field (register pair) |
| dec_cond | output | 3 | Condition code, 4 = always |
| dec_imm | output | 16 | Assembled immediate or fixed address |
| dec_cycles | output | 5 | Base cycle cost |
| illegal_op | output | 1 | One-cycle pulse on an unused opcode |

## Verification
The bench sweeps all 256 unprefixed opcodes and all 256 second bytes after the prefix. For each one it counts the fetches and checks their addresses.

- A wrong operand-length decode shows up as a wrong fetch count, and every following instruction is then misaligned.
- Swapped operand bytes corrupt the immediate.
- A missing sign extension breaks the negative displacements.
- A missed unused slot decodes garbage instead of pulsing the illegal flag.
- An illegal opcode that still consumes operand bytes skips the next instruction.

The first record is held unaccepted for several cycles. A sequencer that fetches ahead or lets the record drift is caught there.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  typedef enum logic [4:0] {
    C_NOP, C_MISC, C_LD_RR, C_LD8_IMM, C_LD16_IMM, C_LD_IND, C_LD_ABS,
    C_LD_HPI, C_LD_HPC, C_LD_SP, C_ALU, C_ALU_IMM, C_INC8, C_INC16,
    C_ADD16, C_SP_ADJ, C_JR, C_JP, C_CALL, C_RET, C_RST, C_PUSH, C_POP,
    C_ACC, C_CB_SH, C_CB_BIT, C_CB_RES, C_CB_SET
  } op_class_e;

  typedef enum logic [2:0] {
    IM_NONE, IM_U8, IM_S8, IM_HP, IM_HPC, IM_U16
  } imm_mode_e;

  localparam logic [2:0] COND_ALWAYS = 3'd4;

  typedef struct packed {
    op_class_e  cls;
    logic [2:0] ysel;
    logic [2:0] zsel;
    logic [1:0] pair;
    logic [2:0] cond;
    imm_mode_e  imode;
    logic [7:0] fixed;
    logic [4:0] cycles;
    logic       prefix;
    logic       illegal;
  } dec_rec_t;

  function automatic logic [1:0] operand_bytes(input imm_mode_e m);
    case (m)
      IM_U8, IM_S8, IM_HP: operand_bytes = 2'd1;
      IM_U16:              operand_bytes = 2'd2;
      default:             operand_bytes = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/opdec_main.sv
module opdec_main
  import opdec_pkg::*;
(
  input  logic [7:0] op,
  output dec_rec_t   rec
);
  logic [1:0] x;
  logic [2:0] y;
  logic [2:0] z;
  logic [1:0] p;
  logic       q;

  assign x = op[7:6];
  assign y = op[5:3];
  assign z = op[2:0];
  assign p = y[2:1];
  assign q = y[0];

  always_comb begin
    rec         = '0;
    rec.cls     = C_NOP;
    rec.ysel    = y;
    rec.zsel    = z;
    rec.pair    = p;
    rec.cond    = COND_ALWAYS;
    rec.imode   = IM_NONE;
    rec.cycles  = 5'd4;
    unique case (x)
      2'd0: begin
        unique case (z)
          3'd0: begin
            if (y == 3'd0) rec.cls = C_NOP;
            else if (y == 3'd1) begin
              rec.cls = C_LD_SP; rec.imode = IM_U16; rec.cycles = 5'd20;
            end else if (y == 3'd2) rec.cls = C_MISC;
            else begin
              rec.cls = C_JR; rec.imode = IM_S8; rec.cycles = 5'd12;
              rec.cond = y[2] ? {1'b0, y[1:0]} : COND_ALWAYS;
            end
          end
          3'd1: begin
            if (q) begin rec.cls = C_ADD16; rec.cycles = 5'd8; end
            else begin rec.cls = C_LD16_IMM; rec.imode = IM_U16; rec.cycles = 5'd12; end
          end
          3'd2: begin rec.cls = C_LD_IND; rec.cycles = 5'd8; end
          3'd3: begin rec.cls = C_INC16; rec.cycles = 5'd8; end
          3'd4, 3'd5: begin
            rec.cls = C_INC8; rec.cycles = (y == 3'd6) ? 5'd12 : 5'd4;
          end
          3'd6: begin
            rec.cls = C_LD8_IMM; rec.imode = IM_U8;
            rec.cycles = (y == 3'd6) ? 5'd12 : 5'd8;
          end
          default: rec.cls = C_ACC;
        endcase
      end
      2'd1: begin
        if (y == 3'd6 && z == 3'd6) rec.cls = C_MISC;
        else begin
          rec.cls = C_LD_RR;
          rec.cycles = (y == 3'd6 || z == 3'd6) ? 5'd8 : 5'd4;
        end
      end
      2'd2: begin
        rec.cls = C_ALU; rec.cycles = (z == 3'd6) ? 5'd8 : 5'd4;
      end
      default: begin
        unique case (z)
          3'd0: begin
            if (!y[2]) begin
              rec.cls = C_RET; rec.cond = {1'b0, y[1:0]}; rec.cycles = 5'd8;
            end else if (y == 3'd4 || y == 3'd6) begin
              rec.cls = C_LD_HPI; rec.imode = IM_HP; rec.cycles = 5'd12;
            end else begin
              rec.cls = C_SP_ADJ; rec.imode = IM_S8;
              rec.cycles = (y == 3'd5) ? 5'd16 : 5'd12;
            end
          end
          3'd1: begin
            if (!q) begin rec.cls = C_POP; rec.cycles = 5'd12; end
            else begin
              unique case (p)
                2'd0, 2'd1: begin rec.cls = C_RET; rec.cycles = 5'd16; end
                2'd2:       rec.cls = C_JP;
                default:    begin rec.cls = C_LD_SP; rec.cycles = 5'd8; end
              endcase
            end
          end
          3'd2: begin
            if (!y[2]) begin
              rec.cls = C_JP; rec.cond = {1'b0, y[1:0]};
              rec.imode = IM_U16; rec.cycles = 5'd12;
            end else if (y == 3'd4 || y == 3'd6) begin
              rec.cls = C_LD_HPC; rec.imode = IM_HPC; rec.cycles = 5'd8;
            end else begin
              rec.cls = C_LD_ABS; rec.imode = IM_U16; rec.cycles = 5'd16;
            end
          end
          3'd3: begin
            if (y == 3'd0) begin
              rec.cls = C_JP; rec.imode = IM_U16; rec.cycles = 5'd16;
            end else if (y == 3'd1) rec.prefix = 1'b1;
            else if (y == 3'd6 || y == 3'd7) rec.cls = C_MISC;
            else rec.illegal = 1'b1;
          end
          3'd4: begin
            if (!y[2]) begin
              rec.cls = C_CALL; rec.cond = {1'b0, y[1:0]};
              rec.imode = IM_U16; rec.cycles = 5'd12;
            end else rec.illegal = 1'b1;
          end
          3'd5: begin
            if (!q) begin rec.cls = C_PUSH; rec.cycles = 5'd16; end
            else if (p == 2'd0) begin
              rec.cls = C_CALL; rec.imode = IM_U16; rec.cycles = 5'd24;
            end else rec.illegal = 1'b1;
          end
          3'd6: begin
            rec.cls = C_ALU_IMM; rec.imode = IM_U8; rec.cycles = 5'd8;
          end
          default: begin
            rec.cls = C_RST; rec.fixed = {2'b00, y, 3'b000}; rec.cycles = 5'd16;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/opdec_ext.sv
module opdec_ext
  import opdec_pkg::*;
(
  input  logic [7:0] op,
  output dec_rec_t   rec
);
  logic [1:0] x;
  logic       mem_operand;

  assign x           = op[7:6];
  assign mem_operand = (op[2:0] == 3'd6);

  always_comb begin
    rec        = '0;
    rec.ysel   = op[5:3];
    rec.zsel   = op[2:0];
    rec.pair   = op[5:4];
    rec.cond   = COND_ALWAYS;
    rec.imode  = IM_NONE;
    rec.prefix = 1'b1;
    unique case (x)
      2'd0:    rec.cls = C_CB_SH;
      2'd1:    rec.cls = C_CB_BIT;
      2'd2:    rec.cls = C_CB_RES;
      default: rec.cls = C_CB_SET;
    endcase
    if (!mem_operand)    rec.cycles = 5'd8;
    else if (x == 2'd1)  rec.cycles = 5'd12;
    else                 rec.cycles = 5'd16;
  end
endmodule

// File: rtl/byte_op_fetch_decode.sv
module byte_op_fetch_decode
  import opdec_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter logic [7:0] HI_PAGE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              dec_valid,
  input  logic              dec_accept,
  output logic [4:0]        dec_class,
  output logic              dec_prefixed,
  output logic [2:0]        dec_ysel,
  output logic [2:0]        dec_zsel,
  output logic [1:0]        dec_pair,
  output logic [2:0]        dec_cond,
  output logic [15:0]       dec_imm,
  output logic [4:0]        dec_cycles,
  output logic              illegal_op
);
  localparam logic [ADDR_W-1:0] PC_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  typedef enum logic [2:0] {ST_OP, ST_CB, ST_LO, ST_HI, ST_OUT} seq_e;

  seq_e              state_q, state_d;
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  dec_rec_t          rec_q, rec_d;
  logic [7:0]        lo_q, lo_d, hi_q, hi_d;
  logic              ill_q, ill_d;
  dec_rec_t          main_rec, ext_rec;

  opdec_main u_main (.op(mem_rdata), .rec(main_rec));
  opdec_ext  u_ext  (.op(mem_rdata), .rec(ext_rec));

  assign mem_rd   = !pend_q && (state_q != ST_OUT);
  assign mem_addr = pc_q;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    pc_d    = pc_q;
    rec_d   = rec_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    ill_d   = 1'b0;
    if (mem_rd) begin
      pc_d   = pc_q + PC_ONE;
      pend_d = 1'b1;
    end else if (pend_q) begin
      pend_d = 1'b0;
      unique case (state_q)
        ST_OP: begin
          rec_d = main_rec;
          if (main_rec.prefix)       state_d = ST_CB;
          else if (main_rec.illegal) begin ill_d = 1'b1; state_d = ST_OP; end
          else if (operand_bytes(main_rec.imode) == 2'd0) state_d = ST_OUT;
          else                       state_d = ST_LO;
        end
        ST_CB: begin rec_d = ext_rec; state_d = ST_OUT; end
        ST_LO: begin
          lo_d    = mem_rdata;
          state_d = (operand_bytes(rec_q.imode) == 2'd2) ? ST_HI : ST_OUT;
        end
        ST_HI: begin hi_d = mem_rdata; state_d = ST_OUT; end
        default: ;
      endcase
    end else if (state_q == ST_OUT && dec_accept) begin
      state_d = ST_OP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;
      pend_q  <= 1'b0;
      pc_q    <= '0;
      rec_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      pc_q    <= pc_d;
      rec_q   <= rec_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      ill_q   <= ill_d;
    end
  end

  always_comb begin
    unique case (rec_q.imode)
      IM_U8:   dec_imm = {8'h00, lo_q};
      IM_S8:   dec_imm = {{8{lo_q[7]}}, lo_q};
      IM_HP:   dec_imm = {HI_PAGE, lo_q};
      IM_HPC:  dec_imm = {HI_PAGE, 8'h00};
      IM_U16:  dec_imm = {hi_q, lo_q};
      default: dec_imm = {8'h00, rec_q.fixed};
    endcase
  end

  assign dec_valid    = (state_q == ST_OUT);
  assign dec_class    = rec_q.cls;
  assign dec_prefixed = rec_q.prefix;
  assign dec_ysel     = rec_q.ysel;
  assign dec_zsel     = rec_q.zsel;
  assign dec_pair     = rec_q.pair;
  assign dec_cond     = rec_q.cond;
  assign dec_cycles   = rec_q.cycles;
  assign illegal_op   = ill_q;

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> pc_q == $past(pc_q) + PC_ONE);
  // R12
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_accept |=> dec_valid && $stable(dec_imm) && $stable(dec_class));
  // R12
  no_fetch_while_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !mem_rd);
  // R11
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> !illegal_op);
  // R11
  illegal_no_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !dec_valid);
  // R11
  valid_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !rec_q.illegal);
endmodule

// File: tb/byte_op_fetch_decode_bench.sv
module byte_op_fetch_decode_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        dec_valid;
  logic        dec_accept = 1'b0;
  logic [4:0]  dec_class;
  logic        dec_prefixed;
  logic [2:0]  dec_ysel, dec_zsel, dec_cond;
  logic [1:0]  dec_pair;
  logic [15:0] dec_imm;
  logic [4:0]  dec_cycles;
  logic        illegal_op;

  logic [7:0]  mem [0:4095];
  int          n_tests = 0;
  int          n_fail  = 0;
  logic [15:0] exp_pc = 16'h0000;
  logic        carry = 1'b0;
  logic [15:0] carry_addr = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

  byte_op_fetch_decode u_byte_op_fetch_decode (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_class(dec_class), .dec_prefixed(dec_prefixed), .dec_ysel(dec_ysel),
    .dec_zsel(dec_zsel), .dec_pair(dec_pair), .dec_cond(dec_cond),
    .dec_imm(dec_imm), .dec_cycles(dec_cycles), .illegal_op(illegal_op));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_illegal(input logic [7:0] op);
    return op inside {8'hD3, 8'hDB, 8'hDD, 8'hE3, 8'hE4, 8'hEB, 8'hEC, 8'hED, 8'hF4, 8'hFC, 8'hFD};
  endfunction

  function automatic int opnd_len(input logic [7:0] op);
    if ((op & 8'hCF) == 8'h01 || op inside {8'h08, 8'hC2, 8'hCA, 8'hD2, 8'hDA, 8'hC3,
        8'hC4, 8'hCC, 8'hD4, 8'hDC, 8'hCD, 8'hEA, 8'hFA}) return 2;
    if ((op & 8'hC7) == 8'h06 || (op & 8'hC7) == 8'hC6 ||
        op inside {8'h18, 8'h20, 8'h28, 8'h30, 8'h38, 8'hE0, 8'hE8, 8'hF0, 8'hF8}) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] exp_imm(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2);
    if (opnd_len(op) == 2) return {b2, b1};
    if (op == 8'hE0 || op == 8'hF0) return {8'hFF, b1};
    if (op inside {8'h18, 8'h20, 8'h28, 8'h30, 8'h38, 8'hE8, 8'hF8}) return {{8{b1[7]}}, b1};
    if (opnd_len(op) == 1) return {8'h00, b1};
    if ((op & 8'hC7) == 8'hC7) return {8'h00, op & 8'h38};
    if (op == 8'hE2 || op == 8'hF2) return 16'hFF00;
    return 16'h0000;
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [7:0] cbop, input int hold_in);
    logic [15:0] start = exp_pc;
    logic [7:0]  b1 = (op == 8'hCB) ? cbop : (op ^ 8'h5A);
    logic [7:0]  b2 = op + 8'h33;
    int          nfetch;
    int          fetched = 0;
    int          hold = hold_in;
    bit          done = 0;
    int          cyc = 0;
    logic [15:0] held_imm = 16'h0;
    mem[start[11:0]]         = op;
    mem[12'(start + 16'd1)]  = b1;
    mem[12'(start + 16'd2)]  = b2;
    if (is_illegal(op)) nfetch = 1;
    else if (op == 8'hCB) nfetch = 2;
    else nfetch = 1 + opnd_len(op);
    if (carry) begin
      chk(carry_addr == start, "R2 fetch address", carry_addr, start);
      fetched = 1;
      carry = 0;
    end
    while (!done && cyc < 40) begin
      @(negedge clk);
      dec_accept = 1'b0;
      cyc++;
      if (illegal_op) begin
        chk(is_illegal(op), "R11 illegal flag", op, 0);
        if (mem_rd) begin carry = 1; carry_addr = mem_addr; end
        done = 1;
      end else begin
        if (mem_rd) begin
          chk(mem_addr == 16'(start + fetched), "R2 fetch address", mem_addr, 16'(start + fetched));
          fetched++;
        end
        if (dec_valid) begin
          if (hold > 0) begin
            // R12: record held, no fetch while waiting
            if (hold != hold_in) chk(dec_imm == held_imm, "R12 record stable", dec_imm, held_imm);
            chk(!mem_rd, "R12 no fetch while held", mem_rd, 0);
            held_imm = dec_imm;
            hold--;
          end else begin
            chk(!is_illegal(op), "R11 illegal decoded as valid", op, 0);
            if (op == 8'hCB) begin
              chk(dec_prefixed == 1'b1 && dec_ysel == cbop[5:3] && dec_zsel == cbop[2:0],
                  "R4 prefixed record", {dec_prefixed, dec_ysel, dec_zsel}, {1'b1, cbop[5:0]});
              chk(dec_imm == 16'h0, "R4 prefixed imm", dec_imm, 0);
              // R13
              chk(dec_cycles == ((cbop[2:0] != 3'd6) ? 5'd8 : (cbop[7:6] == 2'd1) ? 5'd12 : 5'd16),
                  "R13 prefixed cycles", dec_cycles, cbop);
            end else begin
              chk(dec_prefixed == 1'b0 && dec_ysel == op[5:3] && dec_zsel == op[2:0] && dec_pair == op[5:4],
                  "R3 field selectors", {dec_prefixed, dec_ysel, dec_zsel, dec_pair}, {1'b0, op[5:0], op[5:4]});
              // R5 R6 R7 R8
              chk(dec_imm == exp_imm(op, b1, b2), "R5/R6/R7/R8 immediate", dec_imm, exp_imm(op, b1, b2));
              if (op inside {8'h01, 8'h11, 8'h21, 8'h31, 8'hE0, 8'hF0, 8'h34})
                chk(dec_cycles == 5'd12, "R10 cycles 12", dec_cycles, 12);
              if (op == 8'hF2) chk(dec_cycles == 5'd8, "R10 cycles 8", dec_cycles, 8);
              if (op == 8'hFA || (op & 8'hC7) == 8'hC7)
                chk(dec_cycles == 5'd16, "R10 cycles 16", dec_cycles, 16);
              if (op == 8'h18) chk(dec_cond == 3'd4, "R9 always cond", dec_cond, 4);
              if (op inside {8'h20, 8'h28, 8'h30, 8'h38})
                chk(dec_cond == {1'b0, op[4:3]}, "R9 jump cond", dec_cond, op[4:3]);
            end
            dec_accept = 1'b1;
            done = 1;
          end
        end
      end
    end
    chk(done, "R2 instruction completes", cyc, 40);
    chk(fetched == nfetch, "R5/R6/R11 byte count", fetched, nfetch);
    exp_pc = start + 16'(nfetch);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(mem_rd && mem_addr == 16'h0 && !dec_valid && !illegal_op, "R1 reset state",
        {mem_rd, mem_addr, dec_valid, illegal_op}, {1'b1, 16'h0, 2'b00});
    rst_n = 1'b1;
    #1;
    chk(mem_rd && mem_addr == 16'h0 && !dec_valid && !illegal_op, "R1 first fetch",
        {mem_rd, mem_addr, dec_valid, illegal_op}, {1'b1, 16'h0, 2'b00});
    carry = 1;
    carry_addr = mem_addr;
    for (int op = 0; op < 256; op++)
      if (op != 8'hCB) run_op(8'(op), 8'h00, (op == 0 || op == 8'hFA) ? 3 : 0);
    for (int cb = 0; cb < 256; cb++) run_op(8'hCB, 8'(cb), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule